// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block keeps the record that software inspects after a bus error caused by an access to physical memory that nothing answers. A one-cycle fault strobe arrives with four qualifiers (write, instruction fetch, alternate address space, supervisor mode) and the 32-bit address of the offending access. On every strobe the block rewrites a fault status word and a fault address word. It also decides from two MMU control bits, enable and no-fault, whether to raise a data-access trap.

The status word is cleared when software reads it. A second fault that lands before that read does not keep the earlier cause fields. The old contents shrink to a single overflow marker, and the new cause fields are merged on top. The block does not decode the address map, translate addresses or vector traps. It turns a fault pulse into register state and a trap pulse.

Top module: `mmu_fault_capture`

## Requirements
- R1: When a fault is recorded while the status word is nonzero and is not being read in that cycle, all earlier bits are discarded and only bit 0 (overflow) is kept, under the new cause fields.
- R2: Bit 16 of the status word is set when the faulting access used an alternate address space.
- R3: Bit 5 of the status word marks supervisor mode, bit 6 marks an instruction fetch and bit 7 marks a write.
- R4: Every recorded fault writes the type code 5 into status bits 4:2 and sets bit 1 (address valid), so a fresh fault with no qualifiers reads 0x16.
- R5: Every fault loads the whole faulting address into the fault address word.
- R6: The trap output rises only for a fault taken with enable = 1 and no-fault = 0. Both words still update for every other setting.
- R7: A read with rd_sel = 0 returns the status word on rd_data in the same cycle and clears it at the next edge. A fault in that same cycle wins and is stored as a fresh fault without bit 0.
- R8: A read with rd_sel = 1 returns the fault address word. That word changes only on a fault, and reading it has no side effect.
- R9: The trap is a single-cycle pulse that appears on the first clock edge after the fault strobe.
- R10: A synchronous active-low reset clears the status word, the address word and the trap output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_strobe | input | 1 | One-cycle fault indication |
| flt_write | input | 1 | Faulting access was a write |
| flt_fetch | input | 1 | Faulting access was an instruction fetch |
| flt_alt | input | 1 | Faulting access used an alternate address space |
| flt_super | input | 1 | Faulting access was made in supervisor mode |
| flt_addr | input | 32 | Address of the faulting access |
| ctl_enable | input | 1 | MMU enable control bit |
| ctl_nofault | input | 1 | MMU no-fault control bit |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the address word |
| rd_data | output | 32 | Read data, combinational from the selected word |
| trap_pulse | output | 1 | Data-access trap request |

## Verification
The assertions assume that a strobe is one cycle long for each fault. They also assume that the qualifiers, the address and the two control bits are valid in the cycle the strobe is high, and that rd_sel is steady while rd_en is high. The bench changes every input only on the falling clock edge. It drops the strobe after one cycle and holds the control bits for the whole fault cycle. Back-to-back faults and a fault that coincides with a status read are driven as directed sequences that stay inside these assumptions.

// File: rtl/mmu_fault_pkg.sv
// Shared constants and types for the fault capture unit.
// Assumes a status word of at least 17 bits so the alternate-space flag fits.
package mmu_fault_pkg;
    localparam int FSR_OVF_BIT    = 0;
    localparam int FSR_VALID_BIT  = 1;
    localparam int FSR_CODE_LSB   = 2;
    localparam int FSR_CODE_W     = 3;
    localparam int FSR_SUPER_BIT  = 5;
    localparam int FSR_FETCH_BIT  = 6;
    localparam int FSR_WRITE_BIT  = 7;
    localparam int FSR_ALT_BIT    = 16;
    localparam logic [FSR_CODE_W-1:0] FT_UNASSIGNED = 3'd5;

    localparam logic RD_SEL_STATUS = 1'b0;
    localparam logic RD_SEL_ADDR   = 1'b1;

    typedef struct packed {
        logic write;
        logic fetch;
        logic alt;
        logic super_mode;
    } fault_cause_t;
endpackage

// File: rtl/fault_cause_enc.sv
// Builds the status bits contributed by one fault from its qualifiers.
// Assumes STAT_W > FSR_ALT_BIT. Purely combinational.
module fault_cause_enc
    import mmu_fault_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  fault_cause_t        cause,
    output logic [STAT_W-1:0]   cause_bits
);
    // Place each qualifier and the fixed type code into its field.
    always_comb begin
        cause_bits = '0;
        cause_bits[FSR_ALT_BIT]   = cause.alt;
        cause_bits[FSR_SUPER_BIT] = cause.super_mode;
        cause_bits[FSR_FETCH_BIT] = cause.fetch;
        cause_bits[FSR_WRITE_BIT] = cause.write;
        cause_bits[FSR_CODE_LSB +: FSR_CODE_W] = FT_UNASSIGNED;
        cause_bits[FSR_VALID_BIT] = 1'b1;
    end
endmodule

// File: rtl/fault_status_reg.sv
// Fault status word: collapses to overflow on a repeat fault, clears on read.
// Assumes strobe is one cycle per fault; a fault beats a same-cycle clear.
module fault_status_reg
    import mmu_fault_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              clear,
    input  logic [STAT_W-1:0] cause_bits,
    output logic [STAT_W-1:0] stat_q
);
    localparam logic [STAT_W-1:0] OVF_ONLY = STAT_W'(1) << FSR_OVF_BIT;

    logic              keep_ovf;
    logic [STAT_W-1:0] stat_d;

    // Next value: fault merge first, then read clear, else hold.
    always_comb begin
        keep_ovf = (stat_q != '0) && !clear;
        stat_d   = stat_q;
        if (strobe)
            stat_d = (keep_ovf ? OVF_ONLY : '0) | cause_bits;
        else if (clear)
            stat_d = '0;
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && stat_q != '0 && !clear) |=> stat_q[FSR_OVF_BIT]); // R1
    AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (stat_q[FSR_CODE_LSB +: FSR_CODE_W] == FT_UNASSIGNED && stat_q[FSR_VALID_BIT])); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (stat_q == '0 || clear)) |=> !stat_q[FSR_OVF_BIT]); // R7
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !strobe) |=> (stat_q == '0)); // R7
endmodule

// File: rtl/fault_addr_reg.sv
// Fault address word: loaded on each fault, otherwise held.
// Assumes the address is valid in the strobe cycle.
module fault_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    // Capture the faulting address on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (strobe) addr_q <= addr_in;
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (addr_q == $past(addr_in))); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(addr_q)); // R8
endmodule

// File: rtl/trap_gate.sv
// Registered trap request, qualified by the MMU enable and no-fault bits.
// Assumes the control bits are steady in the strobe cycle.
module trap_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic enable,
    input  logic nofault,
    output logic trap_q
);
    // One-cycle trap pulse after a qualifying fault.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= strobe && enable && !nofault;
    end

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $past(strobe && enable && !nofault)); // R6
    AST_TRAP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && enable && !nofault) |=> trap_q); // R9
    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_q && !$past(strobe)) |-> 1'b0); // R9
endmodule

// File: rtl/mmu_fault_capture.sv
// Top of the fault capture unit: cause encoding, both registers, trap gate
// and the read port. Assumes one strobe cycle per fault; a status read is
// destructive, an address read is not.
module mmu_fault_capture
    import mmu_fault_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_strobe,
    input  logic              flt_write,
    input  logic              flt_fetch,
    input  logic              flt_alt,
    input  logic              flt_super,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              ctl_enable,
    input  logic              ctl_nofault,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [RD_W-1:0]   rd_data,
    output logic              trap_pulse
);
    localparam int RD_W = (ADDR_W > STAT_W) ? ADDR_W : STAT_W;

    fault_cause_t      cause;
    logic [STAT_W-1:0] cause_bits;
    logic [STAT_W-1:0] stat_q;
    logic [ADDR_W-1:0] addr_q;
    logic              stat_clear;

    // Bundle the qualifiers for the encoder.
    always_comb begin
        cause.write      = flt_write;
        cause.fetch      = flt_fetch;
        cause.alt        = flt_alt;
        cause.super_mode = flt_super;
    end

    // A status read clears the word at the next edge.
    assign stat_clear = rd_en && (rd_sel == RD_SEL_STATUS);

    fault_cause_enc #(.STAT_W(STAT_W)) u_enc (
        .cause      (cause),
        .cause_bits (cause_bits)
    );

    fault_status_reg #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (flt_strobe),
        .clear      (stat_clear),
        .cause_bits (cause_bits),
        .stat_q     (stat_q)
    );

    fault_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (flt_strobe),
        .addr_in (flt_addr),
        .addr_q  (addr_q)
    );

    trap_gate u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (flt_strobe),
        .enable  (ctl_enable),
        .nofault (ctl_nofault),
        .trap_q  (trap_pulse)
    );

    // Read mux, zero-extended to the port width.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_sel == RD_SEL_ADDR) rd_data = RD_W'(addr_q);
            else                       rd_data = RD_W'(stat_q);
        end
    end

    AST_ALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |=> (stat_q[FSR_ALT_BIT] == $past(flt_alt))); // R2
    AST_MODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |=> (stat_q[FSR_WRITE_BIT] == $past(flt_write)
                     && stat_q[FSR_FETCH_BIT] == $past(flt_fetch)
                     && stat_q[FSR_SUPER_BIT] == $past(flt_super))); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0 && addr_q == '0 && !trap_pulse)); // R10
endmodule

// File: tb/tb_mmu_fault_capture.sv
`timescale 1ns/1ps
module tb_mmu_fault_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_strobe = 1'b0, flt_write = 1'b0, flt_fetch = 1'b0;
    logic        flt_alt = 1'b0, flt_super = 1'b0;
    logic [31:0] flt_addr = '0;
    logic        ctl_enable = 1'b0, ctl_nofault = 1'b0;
    logic        rd_en = 1'b0, rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        trap_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mmu_fault_capture dut (
        .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe), .flt_write(flt_write),
        .flt_fetch(flt_fetch), .flt_alt(flt_alt), .flt_super(flt_super),
        .flt_addr(flt_addr), .ctl_enable(ctl_enable), .ctl_nofault(ctl_nofault),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .trap_pulse(trap_pulse)
    );

    // Vector table: qualifiers {write,fetch,alt,super}, controls {enable,nofault}.
    localparam int NV = 6;
    localparam logic [3:0]  T_Q    [NV] = '{4'b0000, 4'b1001, 4'b0100, 4'b0010, 4'b1111, 4'b1010};
    localparam logic [1:0]  T_CTL  [NV] = '{2'b10,   2'b11,   2'b00,   2'b01,   2'b10,   2'b10};
    localparam logic [31:0] T_ADDR [NV] = '{32'h0000_1000, 32'h8000_0004, 32'hFFFF_FFFC,
                                            32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000};
    localparam logic [31:0] T_STAT [NV] = '{32'h16, 32'hB6, 32'h56, 32'h1_0016, 32'h1_00F6, 32'h1_0096};
    localparam logic        T_TRAP [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input bit ovf, input logic [3:0] q);
        return {15'd0, q[1], 8'd0, q[3], q[2], q[0], 5'b10110} | {31'd0, ovf};
    endfunction

    // Drive one fault for a cycle; returns trap seen after the edge.
    task automatic fault(input logic [3:0] q, input logic [1:0] ctl,
                         input logic [31:0] a, output logic trap_seen);
        @(negedge clk);
        {flt_write, flt_fetch, flt_alt, flt_super} = q;
        {ctl_enable, ctl_nofault} = ctl;
        flt_addr = a;
        flt_strobe = 1'b1;
        @(negedge clk);
        flt_strobe = 1'b0;
        trap_seen = trap_pulse;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 trap after reset", {31'd0, trap_pulse}, 32'd0);
        rd(1'b1, v); chk("R10 address after reset", v, 32'd0);
        rd(1'b0, v); chk("R10 status after reset", v, 32'd0);

        // R2 R3 R4 R5 R6 R9: table walk, each fault read back and cleared
        for (int i = 0; i < NV; i++) begin
            fault(T_Q[i], T_CTL[i], T_ADDR[i], t);
            chk("R6 R9 trap per vector", {31'd0, t}, {31'd0, T_TRAP[i]});
            @(negedge clk);
            chk("R9 trap drops after one cycle", {31'd0, trap_pulse}, 32'd0);
            rd(1'b1, v); chk("R5 address per vector", v, T_ADDR[i]);
            rd(1'b0, v); chk("R2 R3 R4 status per vector", v, T_STAT[i]);
        end

        // R2 R3 R4: every qualifier combination, fresh fault each time
        for (int q = 0; q < 16; q++) begin
            fault(4'(q), 2'b10, 32'h4000_0000 + 32'(q), t);
            rd(1'b0, v); chk("R3 R2 qualifier sweep", v, exp_stat(1'b0, 4'(q)));
        end

        // R7: status cleared by the previous read
        rd(1'b0, v); chk("R7 cleared after read", v, 32'd0);

        // R1: back-to-back faults without a read collapse to overflow
        fault(4'b1000, 2'b10, 32'h0000_0A00, t);
        fault(4'b0010, 2'b10, 32'h0000_0B00, t);
        rd(1'b1, v); chk("R5 second fault address", v, 32'h0000_0B00);
        rd(1'b0, v); chk("R1 overflow collapse", v, 32'h0001_0017);

        // R1: three faults still only one overflow bit, earlier fields gone
        fault(4'b1111, 2'b00, 32'h1, t);
        fault(4'b0000, 2'b00, 32'h2, t);
        fault(4'b0100, 2'b00, 32'h3, t);
        rd(1'b0, v); chk("R1 triple fault", v, 32'h0000_0057);

        // R7: fault in the same cycle as a status read wins, no overflow
        fault(4'b1000, 2'b10, 32'hAAAA_0000, t);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 1'b0;
        {flt_write, flt_fetch, flt_alt, flt_super} = 4'b0001;
        flt_addr = 32'hBBBB_0000; flt_strobe = 1'b1;
        #1 chk("R7 same-cycle read returns old", rd_data, 32'h0000_0096);
        @(negedge clk);
        flt_strobe = 1'b0; rd_en = 1'b0;
        rd(1'b0, v); chk("R7 fault beats clear", v, 32'h0000_0036);

        // R8: address reads and idle cycles leave address and status alone
        fault(4'b0000, 2'b01, 32'h5555_AAAA, t);
        chk("R6 no trap when enable low", {31'd0, t}, 32'd0);
        rd(1'b1, v);
        repeat (4) @(negedge clk);
        rd(1'b1, v); chk("R8 address held", v, 32'h5555_AAAA);
        rd(1'b0, v); chk("R8 address read has no side effect", v, 32'h16);
        rd(1'b1, v); chk("R8 address kept after status read", v, 32'h5555_AAAA);

        // R10: reset in mid-use
        fault(4'b1111, 2'b10, 32'h7777_0000, t);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 trap cleared", {31'd0, trap_pulse}, 32'd0);
        rd(1'b1, v); chk("R10 address cleared", v, 32'd0);
        rd(1'b0, v); chk("R10 status cleared", v, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        done = 1'b1;
        $finish;
    end
endmodule